// File: doc/BRIEF.md
# Register Stack With Flags

This block is a last-in first-out store held in a small array of registers. A wrapping stack pointer marks the current top entry. A push first moves the pointer up by one slot and then writes the incoming word at the new position. A pop first copies the word at the pointer into an output data register and then moves the pointer down by one. The pointer is exactly as wide as the array address, so it wraps by itself. The two status flags come from that wrap alone. The stack is full when a push carries the pointer round to zero, and it is empty when a pop brings it back to zero.

The block takes at most one operation per clock. A push aimed at a full stack and a pop aimed at an empty stack are both refused, and each such refusal produces a one-cycle error pulse. When push and pop are requested in the same cycle, the pop is carried out and the push is thrown away. The reset input is asserted asynchronously, active low, and its release is synchronised inside the block.

Top module: `lifo_regstack`

## Requirements
- R1: While reset is asserted and after it is released, the pointer is zero, `empty_o` is 1, `full_o` is 0, both error pulses are 0 and `pop_data_o` is all zeros.
- R2: An accepted push writes `push_data_i` one slot above the current top. From the following cycle `empty_o` is 0.
- R3: An accepted pop presents the most recently pushed word that has not yet been popped on `pop_data_o` one cycle later. `pop_data_o` keeps its value until the next accepted pop.
- R4: With the default 64 entries, `full_o` rises the cycle after the 64th accepted push, when the pointer wraps to zero. It is 0 at every smaller fill level.
- R5: `empty_o` rises the cycle after the pop that removes the last entry. Any accepted pop clears `full_o`.
- R6: A push while `full_o` is 1 and no pop is requested leaves the contents, the pointer and the flags unchanged, and raises `ovf_o` for exactly one cycle.
- R7: A pop while `empty_o` is 1 leaves `pop_data_o`, the pointer and the flags unchanged, and raises `unf_o` for exactly one cycle.
- R8: When push and pop are requested together, only the pop is applied and the push word is discarded. If the stack is empty, the result is an underflow with no write.
- R9: `full_o` and `empty_o` are never 1 together, and `ovf_o` and `unf_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle, takes priority over push |
| push_data_i | input | DW | Word to be pushed |
| pop_data_o | output | DW | Data register loaded by each accepted pop |
| full_o | output | 1 | Stack holds the maximum number of entries |
| empty_o | output | 1 | Stack holds no entries |
| ovf_o | output | 1 | One-cycle pulse: a push was refused because the stack was full |
| unf_o | output | 1 | One-cycle pulse: a pop was refused because the stack was empty |

## Verification
Every result lands exactly one clock after the request is sampled: the popped word, both flags and both error pulses are all registered at the same edge. The bench drives each request on a falling edge. It then waits through the next rising edge and compares all outputs at the falling edge that follows, against a level-indexed reference stack updated for that same request. Refused requests are checked at the same point for unchanged data and flags. Their effect on the stored contents shows up in the later pops.

// File: rtl/lifo_regstack_pkg.sv
package lifo_regstack_pkg;

  typedef enum logic [2:0] {
    STK_IDLE = 3'd0,
    STK_PUSH = 3'd1,
    STK_POP  = 3'd2,
    STK_OVF  = 3'd3,
    STK_UNF  = 3'd4
  } stk_op_e;

endpackage

// File: rtl/lifo_rst_sync.sv
module lifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_regstack_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o
);

  localparam logic [AW-1:0] PTR_ONE  = AW'(1);
  localparam logic [AW-1:0] PTR_ZERO = '0;

  stk_op_e       op;
  logic [AW-1:0] sp_q, sp_d, sp_up, sp_dn;
  logic          full_q, full_d, empty_q, empty_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          sp_en, flag_en;

  // Request decode: pop wins over push, refused requests become errors
  always_comb begin
    op = STK_IDLE;
    if (pop_i) begin
      if (empty_q) op = STK_UNF;
      else         op = STK_POP;
    end else if (push_i) begin
      if (full_q)  op = STK_OVF;
      else         op = STK_PUSH;
    end
  end

  assign sp_up = sp_q + PTR_ONE;
  assign sp_dn = sp_q - PTR_ONE;

  // Next-state logic
  always_comb begin
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    sp_en   = 1'b0;
    flag_en = 1'b0;
    ovf_d   = (op == STK_OVF);
    unf_d   = (op == STK_UNF);
    case (op)
      STK_PUSH: begin
        sp_en   = 1'b1;
        flag_en = 1'b1;
        sp_d    = sp_up;
        full_d  = (sp_up == PTR_ZERO);
        empty_d = 1'b0;
      end
      STK_POP: begin
        sp_en   = 1'b1;
        flag_en = 1'b1;
        sp_d    = sp_dn;
        empty_d = (sp_dn == PTR_ZERO);
        full_d  = 1'b0;
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (flag_en) begin
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign wr_en   = (op == STK_PUSH);
  assign wr_addr = sp_up;
  assign rd_en   = (op == STK_POP);
  assign rd_addr = sp_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  // R3 / R2: pointer moves one step per accepted operation
  a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_q) |=> (sp_q == $past(sp_q) + PTR_ONE) && !empty_q);

  // R6: refused push keeps pointer and flags, raises overflow
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_q) |=> ovf_q && $stable(sp_q) && full_q);

  // R7: refused pop keeps pointer and flags, raises underflow
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_q) |=> unf_q && $stable(sp_q) && empty_q);

  // R8: with both requested the pointer moves down
  a_r8_pop_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && push_i && !empty_q) |=> (sp_q == $past(sp_q) - PTR_ONE) && !full_q);

  // R9: flags and error pulses exclusive
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));

  a_r9_errors_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_q, unf_q}));

  // R4 / R5: flags only when pointer rests at zero
  a_r4_full_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q || empty_q) |-> (sp_q == PTR_ZERO));

endmodule

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] slot_we;
  logic [DW-1:0]    rd_q;

  // Per-slot write enable decode
  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = wr_en && (wr_addr == AW'(g));
  end

  // Storage array: no reset, written only on an accepted push
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem_q[i] <= wr_data;
    end
  end

  // Output data register, loaded on an accepted pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= mem_q[rd_addr];
  end

  assign rd_data = rd_q;

  // R3: popped data holds between accepted pops
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));

  // R8: the write and read ports are never active in the same cycle
  a_r8_single_port_use: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] pop_data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o,
  output logic          unf_o
);

  logic          rst_n_s;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  lifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lifo_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  lifo_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (push_data_i),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (pop_data_o)
  );

  // R1: flags at reset state
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (empty_o && !full_o && !ovf_o && !unf_o));

endmodule

// File: tb/sim_lifo_regstack.sv
`timescale 1ns/1ps
module sim_lifo_regstack;

  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_i, pop_i;
  logic [DW-1:0] push_data_i;
  logic [DW-1:0] pop_data_o;
  logic          full_o, empty_o, ovf_o, unf_o;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model
  logic [DW-1:0] ref_stk [DEPTH];
  int            ref_cnt = 0;
  logic [DW-1:0] ref_dout = '0;
  logic          ref_ovf = 1'b0;
  logic          ref_unf = 1'b0;

  always #2 clk = ~clk;

  lifo_regstack #(.DW(DW), .AW(AW)) u0 (
    .clk, .rst_n, .push_i, .pop_i, .push_data_i,
    .pop_data_o, .full_o, .empty_o, .ovf_o, .unf_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_full();
    return (ref_cnt == DEPTH);
  endfunction

  function automatic logic exp_empty();
    return (ref_cnt == 0);
  endfunction

  task automatic model(input logic ps, input logic pp, input logic [DW-1:0] d);
    ref_ovf = 1'b0;
    ref_unf = 1'b0;
    if (pp) begin
      if (ref_cnt == 0) ref_unf = 1'b1;
      else begin
        ref_dout = ref_stk[ref_cnt-1];
        ref_cnt--;
      end
    end else if (ps) begin
      if (ref_cnt == DEPTH) ref_ovf = 1'b1;
      else begin
        ref_stk[ref_cnt] = d;
        ref_cnt++;
      end
    end
  endtask

  task automatic step(input logic ps, input logic pp, input logic [DW-1:0] d);
    push_i      = ps;
    pop_i       = pp;
    push_data_i = d;
    @(posedge clk);
    @(negedge clk);
    model(ps, pp, d);
    chk("R3 pop_data", 32'(pop_data_o), 32'(ref_dout));
    chk("R4 full", 32'(full_o), 32'(exp_full()));
    chk("R5 empty", 32'(empty_o), 32'(exp_empty()));
    chk("R6 ovf", 32'(ovf_o), 32'(ref_ovf));
    chk("R7 unf", 32'(unf_o), 32'(ref_unf));
    chk("R9 exclusive", 32'((full_o && empty_o) || (ovf_o && unf_o)), 32'(0));
    if (ps && !pp && !ref_ovf) chk("R2 empty clear after push", 32'(empty_o), 32'(0));
    if (ps && pp) chk("R8 pop wins", 32'(pop_data_o), 32'(ref_dout));
    push_i = 1'b0;
    pop_i  = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    push_i = 1'b0; pop_i = 1'b0; push_data_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 empty in reset", 32'(empty_o), 32'(1));
    chk("R1 full in reset", 32'(full_o), 32'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 empty", 32'(empty_o), 32'(1));
    chk("R1 full", 32'(full_o), 32'(0));
    chk("R1 errors", 32'({ovf_o, unf_o}), 32'(0));
    chk("R1 pop_data", 32'(pop_data_o), 32'(0));

    // R7: pop on empty, then R8 with empty stack
    step(1'b0, 1'b1, '0);
    step(1'b1, 1'b1, 16'hDEAD);   // R8 push dropped, underflow
    chk("R8 push dropped when empty", 32'(empty_o), 32'(1));

    // R2/R3: small LIFO order
    step(1'b1, 1'b0, 16'h1111);
    step(1'b1, 1'b0, 16'h2222);
    step(1'b1, 1'b0, 16'h3333);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b1, '0);
    chk("R3 top first", 32'(pop_data_o), 32'h3333);
    step(1'b1, 1'b1, 16'hBEEF);   // R8: pops 2222
    chk("R8 pop data", 32'(pop_data_o), 32'h2222);
    step(1'b0, 1'b1, '0);
    chk("R3 last", 32'(pop_data_o), 32'h1111);
    chk("R5 empty after last pop", 32'(empty_o), 32'(1));

    // R4: fill completely, R6: push on full
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DW'(16'hA000 + i));
    chk("R4 full after 64", 32'(full_o), 32'(1));
    step(1'b1, 1'b0, 16'hFFFF);
    chk("R6 ovf pulse", 32'(ovf_o), 32'(1));
    step(1'b0, 1'b0, '0);
    chk("R6 pulse one cycle", 32'(ovf_o), 32'(0));
    step(1'b1, 1'b1, 16'h7777);   // R8 on full
    chk("R5 pop clears full", 32'(full_o), 32'(0));
    chk("R6 discarded push not stored", 32'(pop_data_o), 32'hA03F);
    for (int i = 0; i < DEPTH - 1; i++) step(1'b0, 1'b1, '0);
    chk("R5 empty after drain", 32'(empty_o), 32'(1));

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      for (int k = 0; k < 700; k++) begin
        int r;
        r = int'($urandom % 10);
        if (ph % 2 == 0) begin
          if (r < 6)      step(1'b1, 1'b0, DW'($urandom));
          else if (r < 8) step(1'b0, 1'b1, '0);
          else if (r < 9) step(1'b1, 1'b1, DW'($urandom));
          else            step(1'b0, 1'b0, '0);
        end else begin
          if (r < 3)      step(1'b1, 1'b0, DW'($urandom));
          else if (r < 8) step(1'b0, 1'b1, '0);
          else if (r < 9) step(1'b1, 1'b1, DW'($urandom));
          else            step(1'b0, 1'b0, '0);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule